// File: doc/BRIEF.md
# Programmable-Wait Expansion ROM Controller

This block runs single accesses to an external parallel Flash or EPROM on a simple expansion bus. A requester hands over one read or one write at a time, with an address and, for a write, a data word. The controller then drives the expansion address, the output data, an active-low chip-select and an active-low write-enable. It holds the access open for a programmable number of bus clock cycles, and for a read it captures the device's data at the end of that window.

A 4-bit wait field sets the length of every access. A value n gives n+1 cycles. For a read the window runs from the cycle in which the address first appears to the cycle in which the data inputs are captured. For a write it runs from the cycle in which the write data first appears to the cycle in which chip-select and write-enable release together. A zero setting is not allowed, so the controller treats it as 1. A mode bit selects a 16-bit bus or an 8-bit bus. The 8-bit bus uses only the low byte of the address and data lines. The wait field and the mode bit live in one configuration register, and each access takes a copy of that register when it is accepted.

Top module: `exp_rom_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) puts the controller in idle with `eb_cs_n` and `eb_we_n` high, `busy` and `rdy` low, and `rdata` zero. It also sets the wait field to 15 and selects the 8-bit bus (`cfg_wide`=0), so the first access after reset keeps chip-select low for 16 cycles.
- R2: A read accepted at a clock edge drives `eb_addr` and pulls `eb_cs_n` low in the next cycle. It keeps them there for exactly n+1 cycles, where n is the wait field. `eb_din` is captured at the clock edge that ends the last of those cycles.
- R3: In the cycle after the last access cycle, `eb_cs_n` is high and `rdy` is high for exactly one cycle. After a read, `rdata` holds the captured value from that cycle onward.
- R4: A write drives `eb_addr` and `eb_dout` and pulls `eb_cs_n` low for n+1 cycles. `eb_we_n` is high in the first of those cycles and low in all the others. `eb_we_n` and `eb_cs_n` rise at the same edge, and that edge is followed by the `rdy` pulse.
- R5: A wait field of 0 behaves exactly like a wait field of 1, giving an access of two cycles.
- R6: Writing the configuration (`cfg_we` with `cfg_tmg`, `cfg_wide`) during an access does not change that access's length, width or address. The next accepted request uses the new values.
- R7: A request (`req_valid` high at a clock edge) is accepted only while `busy` is low. `busy` rises at the accepting edge and falls at the edge that raises `rdy`. Requests made while `busy` is high are ignored.
- R8: With `cfg_wide`=1 all 16 address and data bits are used. With `cfg_wide`=0 only `eb_addr[7:0]`, `eb_dout[7:0]` and `eb_din[7:0]` are used, and the upper bits of `eb_addr`, `eb_dout` and `rdata` are zero.
- R9: `eb_doe` is high only during the cycles of a write access. While no access is open, `eb_addr` and `eb_dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the configuration register |
| cfg_tmg | input | 4 | Wait field value n (access lasts n+1 cycles) |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last captured read data |
| eb_addr | output | 16 | Expansion bus address |
| eb_dout | output | 16 | Expansion bus write data |
| eb_doe | output | 1 | Write data output enable |
| eb_din | input | 16 | Expansion bus read data |
| eb_cs_n | output | 1 | Chip-select, active low |
| eb_we_n | output | 1 | Write-enable, active low |

## Verification
The bench changes `eb_din` on every cycle, so the captured value shows which edge was sampled. A design that captures one edge early or late therefore returns a word that differs from the model's. It sets the wait field to 0 to catch a design that finishes with no wait state, and it rewrites the field in the middle of an access to catch one that reads the field live instead of taking a copy. It also raises new requests while an access is running, which exposes a controller that accepts them or lets them change the open access. Narrow-mode writes and reads with all bits of the address and data set show any upper bits that leak onto the bus, and each write is checked to see that write-enable stays high in its first cycle and releases together with chip-select.

// File: rtl/exp_rom_ctrl.sv
module exp_rom_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_tmg,
  input  logic          cfg_wide,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] eb_addr,
  output logic [DW-1:0] eb_dout,
  output logic          eb_doe,
  input  logic [DW-1:0] eb_din,
  output logic          eb_cs_n,
  output logic          eb_we_n
);
  localparam int HD = DW / 2;
  localparam int HA = AW / 2;
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [TW-1:0] TONE = TW'(1);

  logic          act, wr, wide_a, wide_q, rdy_q;
  logic [TW-1:0] cnt, lim, tmg_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      wr     <= 1'b0;
      wide_a <= 1'b0;
      wide_q <= 1'b0;
      tmg_q  <= TMAX;
      cnt    <= '0;
      lim    <= TONE;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      if (cfg_we) begin
        tmg_q  <= cfg_tmg;
        wide_q <= cfg_wide;
      end
      if (!act) begin
        if (req_valid) begin
          act    <= 1'b1;
          wr     <= req_write;
          lim    <= (tmg_q == '0) ? TONE : tmg_q;
          wide_a <= wide_q;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          cnt    <= '0;
        end
      end else if (cnt == lim) begin
        act   <= 1'b0;
        rdy_q <= 1'b1;
        if (!wr)
          rd_q <= wide_a ? eb_din : {{(DW-HD){1'b0}}, eb_din[HD-1:0]};
      end else begin
        cnt <= cnt + TONE;
      end
    end
  end

  assign busy    = act;
  assign rdy     = rdy_q;
  assign rdata   = rd_q;
  assign eb_cs_n = !act;
  assign eb_we_n = !(act && wr && (cnt != '0));
  assign eb_doe  = act && wr;
  assign eb_addr = !act ? '0 : (wide_a ? addr_q : {{(AW-HA){1'b0}}, addr_q[HA-1:0]});
  assign eb_dout = !eb_doe ? '0 : (wide_a ? wd_q : {{(DW-HD){1'b0}}, wd_q[HD-1:0]});
endmodule

// File: rtl/exp_rom_ctrl_chk.sv
module exp_rom_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          rdy,
  input logic          eb_cs_n,
  input logic          eb_we_n,
  input logic          eb_doe,
  input logic [AW-1:0] eb_addr
);
  int unsigned low_len;

  always_ff @(posedge clk) begin
    if (rst)           low_len <= 0;
    else if (!eb_cs_n) low_len <= low_len + 1;
    else               low_len <= 0;
  end

  assert_we_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
    !eb_we_n |-> !eb_cs_n);

  assert_we_late_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(eb_cs_n) |-> eb_we_n);

  assert_rdy_single_R3: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

  assert_rdy_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (!busy && $past(busy)));

  assert_doe_in_access_R9: assert property (@(posedge clk) disable iff (rst)
    eb_doe |-> !eb_cs_n);

  assert_window_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(eb_cs_n) |-> (low_len >= 2 && low_len <= 16));

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
    (!eb_cs_n && $past(!eb_cs_n)) |-> $stable(eb_addr));
endmodule

bind exp_rom_ctrl exp_rom_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rdy(rdy), .eb_cs_n(eb_cs_n),
  .eb_we_n(eb_we_n), .eb_doe(eb_doe), .eb_addr(eb_addr)
);

// File: tb/exp_rom_ctrl_tb.sv
module exp_rom_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        cfg_we = 0, cfg_wide = 0, req_valid = 0, req_write = 0;
  logic [3:0]  cfg_tmg = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, eb_din = 0;
  logic        busy, rdy, eb_doe, eb_cs_n, eb_we_n;
  logic [15:0] rdata, eb_addr, eb_dout;

  int errors = 0, checks = 0, cyc = 0;
  int low_cnt = 0, last_len = 0;

  // behavioural reference state
  int     m_tmg, m_len, m_age;
  bit     m_act, m_wr, m_wide, m_aw, m_rdy;
  int     m_addr, m_wd, m_rd;

  exp_rom_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tmg(cfg_tmg), .cfg_wide(cfg_wide),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rdy(rdy), .rdata(rdata),
    .eb_addr(eb_addr), .eb_dout(eb_dout), .eb_doe(eb_doe), .eb_din(eb_din),
    .eb_cs_n(eb_cs_n), .eb_we_n(eb_we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int nt;
    bit nw;
    if (rst) begin
      m_act = 0; m_wr = 0; m_tmg = 15; m_wide = 0; m_aw = 0; m_rdy = 0;
      m_rd = 0; m_addr = 0; m_wd = 0; m_age = 0; m_len = 2;
    end else begin
      nt = m_tmg; nw = m_wide;
      if (cfg_we) begin nt = cfg_tmg; nw = cfg_wide; end
      m_rdy = 0;
      if (!m_act) begin
        if (req_valid) begin
          m_act = 1; m_wr = req_write; m_aw = m_wide;
          m_len = (m_tmg == 0) ? 2 : m_tmg + 1;
          m_addr = req_addr; m_wd = req_wdata; m_age = 0;
        end
      end else if (m_age == m_len - 1) begin
        m_act = 0; m_rdy = 1;
        if (!m_wr) m_rd = m_aw ? int'(eb_din) : int'(eb_din) & 'hFF;
      end else begin
        m_age++;
      end
      m_tmg = nt; m_wide = nw;
    end
  end

  always @(negedge clk) begin
    cyc++;
    eb_din <= 16'(cyc * 16'h1357 + 16'h0A5C);
    if (!eb_cs_n) low_cnt++;
    else if (low_cnt > 0) begin last_len = low_cnt; low_cnt = 0; end
    if (!rst) begin
      cmp(eb_cs_n, !m_act, "R2 cs_n");
      cmp(eb_we_n, !(m_act && m_wr && m_age >= 1), "R4 we_n");
      cmp(rdy, m_rdy, "R3 rdy");
      cmp(rdata, m_rd, "R3 rdata");
      cmp(busy, m_act, "R7 busy");
      cmp(eb_doe, m_act && m_wr, "R9 doe");
      cmp(eb_addr, !m_act ? 0 : (m_aw ? m_addr : m_addr & 'hFF), "R8 addr");
      cmp(eb_dout, !(m_act && m_wr) ? 0 : (m_aw ? m_wd : m_wd & 'hFF), "R8 dout");
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_cfg(input int t, input bit w);
    @(negedge clk); cfg_we = 1; cfg_tmg = 4'(t); cfg_wide = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic issue(input bit w, input int a, input int d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = 16'(a); req_wdata = 16'(d);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic finish_len(input int exp, input string tag);
    while (!rdy) @(negedge clk);
    @(negedge clk); #1;
    cmp(last_len, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    cmp(eb_cs_n, 1, "R1 cs_n idle");
    cmp(eb_we_n, 1, "R1 we_n idle");
    cmp(busy, 0, "R1 busy idle");
    cmp(rdata, 0, "R1 rdata");
    rst = 0;
    issue(0, 'hFFFF, 0);              finish_len(16, "R1 default wait 15");
    set_cfg(1, 1);
    issue(0, 'hABCD, 0);              finish_len(2, "R2 read n=1");
    set_cfg(3, 1);
    issue(0, 'h1234, 0);              finish_len(4, "R2 read n=3");
    issue(1, 'h4321, 'hC3A5);         finish_len(4, "R4 write n=3");
    set_cfg(0, 1);
    issue(0, 'h0F0F, 0);              finish_len(2, "R5 zero read");
    issue(1, 'hF0F0, 'h5A5A);         finish_len(2, "R5 zero write");
    set_cfg(5, 1);
    issue(0, 'h2222, 0);
    set_cfg(2, 0);
    @(negedge clk); req_valid = 1; req_addr = 'h9999; req_write = 1;
    @(negedge clk); req_valid = 0;
    finish_len(6, "R6 mid-access change ignored");
    cmp(last_len, 6, "R7 busy request ignored");
    issue(1, 'hFFFF, 'hFFFF);         finish_len(3, "R6 new field used");
    issue(0, 'hFFFF, 0);              finish_len(3, "R8 narrow read");
    set_cfg(15, 1);
    issue(1, 'h8001, 'h8001);         finish_len(16, "R4 write n=15");
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule